// File: doc/BRIEF.md
# Daisy-Chained ADC Serial Controller

This block is a serial master for a chain of three successive-approximation ADCs that share one conversion-start line, one serial clock, one controller-to-chain data line and one chain-to-controller data line. It generates the serial clock itself from a programmable divider of the system clock. This lets it hold the clock at a chosen level across conversion-start edges instead of being limited to a fixed clock mode.

It has two jobs. A configuration load enters the devices' load mode by lowering the conversion-start line while the serial clock is high. It then shifts one 8-bit configuration word per device and commits the words by raising the conversion-start line. A conversion cycle raises the conversion-start line and waits, up to a bounded time, for the chain's data line to signal completion. It then lowers the conversion-start line and clocks out the whole 49-bit result frame in one continuous burst. The frame is one busy bit followed by three 16-bit words. The three words are presented together with a one-cycle valid strobe.

The state machine has eleven states. S_IDLE goes to S_CFG_ARM on `start_config`, or to S_CNV_WAIT on `start_convert`. The configuration path runs S_CFG_ARM → S_CFG_ENTER → S_CFG_LOW ⇄ S_CFG_HIGH, then S_CFG_HIGH → S_CFG_COMMIT on the last bit, then S_CFG_RELEASE → S_IDLE. The conversion path leaves S_CNV_WAIT either to S_CNV_DROP when data is ready or to S_IDLE on timeout. From S_CNV_DROP it runs S_CNV_DROP → S_RD_HIGH ⇄ S_RD_LOW, then S_RD_HIGH → S_IDLE on the last frame bit. Every state except S_IDLE and S_CNV_WAIT lasts exactly one serial half-period.

Top module: `adc_chain_ctrl`

## Requirements
- R1: After reset and whenever idle, `sclk`, `cnvst`, `sdo`, `busy`, `rd_valid` and `timeout_err` are all 0.
- R2: A configuration load drives `sclk` high for one half-period, with `cnvst` high, before `cnvst` falls. `sclk` is still high at the moment `cnvst` falls.
- R3: Between that falling edge and the next `cnvst` rise there are exactly 24 rising edges of `sclk`. The bits on `sdo` at those edges are `cfg_word` repeated three times, MSB first. `sdo` changes only at falling edges.
- R4: After the 24th rising edge, `cnvst` rises while `sclk` is still high. Then exactly one `sclk` falling edge occurs with `cnvst` high. Then `cnvst` returns low and the block is idle.
- R5: An accepted `start_convert` raises `cnvst` with `sclk` held low. `sdi` = 1 marks the data as ready. When `sdi` is first seen high on the j-th system clock after `cnvst` rose, `cnvst` falls exactly j cycles after it rose.
- R6: If `sdi` has not been seen high by the TIMEOUT_CYC-th cycle after `cnvst` rose, `cnvst` falls at that cycle, no serial clock is produced and `timeout_err` goes to 1. `sdi` high on exactly that cycle still counts as ready, with no error. `timeout_err` stays 1 until the next accepted `start_convert` clears it.
- R7: `cnvst` is low at every rising edge of `sclk` during a readout.
- R8: A readout is exactly 49 rising edges of `sclk` at a constant period, with no gap, and `sdi` is sampled at each rising edge.
- R9: The first sampled bit (busy) is discarded. The next 16 bits, MSB first, go to `rd_data[15:0]`, the following 16 to `rd_data[31:16]` and the last 16 to `rd_data[47:32]`.
- R10: `rd_valid` is a one-cycle pulse one half-period after the 49th rising edge, and `rd_data` changes only with that pulse.
- R11: With `sclk_half` = h (0 acts as 1), every serial half-period is h system cycles. The first readout rising edge comes h cycles after `cnvst` falls.
- R12: `start_config` and `start_convert` are acted on only in S_IDLE, and `start_config` wins if both are asserted in the same cycle. `busy` is 1 in every state except S_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_config | input | 1 | Request a configuration load |
| start_convert | input | 1 | Request a conversion and readout |
| cfg_word | input | CFG_W | Configuration byte sent to every device |
| sclk_half | input | DIV_W | Serial half-period in system cycles (0 acts as 1) |
| sdi | input | 1 | Serial data from the chain; high means conversion done |
| sclk | output | 1 | Serial clock to the chain |
| cnvst | output | 1 | Conversion-start / load-control line |
| sdo | output | 1 | Serial configuration data to the chain |
| busy | output | 1 | Controller is not idle |
| rd_valid | output | 1 | One-cycle strobe when rd_data is updated |
| rd_data | output | N_DEV*RES_W | Results; result k at bits [16k+15:16k] |
| timeout_err | output | 1 | Ready indication did not arrive in time |

## Verification
Two things can land in the same cycle here: the data-ready indication on `sdi` and the expiry of the conversion timeout. The bench raises `sdi` on exactly the TIMEOUT_CYC-th cycle after the `cnvst` rise, where a full readout with no error is expected. It also runs a case with `sdi` never arriving, where the error and an early `cnvst` fall are expected. A second collision comes from asserting both start requests in one idle cycle, where only a configuration load may follow. Each case is swept over several divider settings, and every timing is judged against cycle counts the bench derives from the half-period.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG_ARM,
        S_CFG_ENTER,
        S_CFG_LOW,
        S_CFG_HIGH,
        S_CFG_COMMIT,
        S_CFG_RELEASE,
        S_CNV_WAIT,
        S_CNV_DROP,
        S_RD_HIGH,
        S_RD_LOW
    } ctrl_state_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    // a half-period of zero is treated as one system cycle
    assign lim_m1 = (half_i == '0) ? '0 : half_i - 1'b1;
    assign tick_o = en_i && (cnt == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en_i || tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DIV_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (cnt == '0)); // R11

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
    parameter int N_DEV = 3,
    parameter int RES_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_i,
    input  logic                   sdi_i,
    input  logic                   commit_i,
    output logic [N_DEV*RES_W-1:0] data_o
);

    localparam int FRAME_W = N_DEV * RES_W + 1;

    logic [FRAME_W-1:0]     sh;
    logic [N_DEV*RES_W-1:0] ordered;

    // first word in the frame lands in the lowest slot
    for (genvar k = 0; k < N_DEV; k++) begin : g_slot
        assign ordered[k*RES_W +: RES_W] = sh[(N_DEV-1-k)*RES_W +: RES_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (sample_i) begin
            sh <= {sh[FRAME_W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (commit_i) begin
            data_o <= ordered;
        end
    end

    AST_RX_NO_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_i && commit_i)); // R10

endmodule

// File: rtl/adc_chain_ctrl.sv
module adc_chain_ctrl
    import adc_chain_pkg::*;
#(
    parameter int N_DEV       = 3,
    parameter int RES_W       = 16,
    parameter int CFG_W       = 8,
    parameter int DIV_W       = 4,
    parameter int TIMEOUT_CYC = 200
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_config,
    input  logic                   start_convert,
    input  logic [CFG_W-1:0]       cfg_word,
    input  logic [DIV_W-1:0]       sclk_half,
    input  logic                   sdi,
    output logic                   sclk,
    output logic                   cnvst,
    output logic                   sdo,
    output logic                   busy,
    output logic                   rd_valid,
    output logic [N_DEV*RES_W-1:0] rd_data,
    output logic                   timeout_err
);

    localparam int CFG_BITS = N_DEV * CFG_W;
    localparam int FRAME_W  = N_DEV * RES_W + 1;
    localparam int MAX_BITS = (FRAME_W > CFG_BITS) ? FRAME_W : CFG_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int TMO_W    = $clog2(TIMEOUT_CYC + 1);

    ctrl_state_t         state, nxt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [TMO_W-1:0]    tmo_cnt;
    logic [CFG_BITS-1:0] cfg_sh;
    logic                tick, div_en;
    logic                last_cfg, last_rd, tmo_hit, cfg_ok, cnv_ok;
    logic                rx_sample, rx_commit;

    assign div_en    = (state != S_IDLE) && (state != S_CNV_WAIT);
    assign last_cfg  = (bit_cnt == CNT_W'(CFG_BITS - 1));
    assign last_rd   = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign tmo_hit   = (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1));
    assign cfg_ok    = (state == S_IDLE) && start_config;
    assign cnv_ok    = (state == S_IDLE) && start_convert && !start_config;
    assign rx_sample = ((state == S_CNV_DROP) || (state == S_RD_LOW)) && tick;
    assign rx_commit = (state == S_RD_HIGH) && tick && last_rd;
    assign sdo       = cfg_sh[CFG_BITS-1];
    assign busy      = (state != S_IDLE);

    adc_sclk_div #(.DIV_W(DIV_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (div_en),
        .half_i (sclk_half),
        .tick_o (tick)
    );

    adc_frame_rx #(.N_DEV(N_DEV), .RES_W(RES_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (rx_sample),
        .sdi_i    (sdi),
        .commit_i (rx_commit),
        .data_o   (rd_data)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start_config)       nxt = S_CFG_ARM;
                else if (start_convert) nxt = S_CNV_WAIT;
            end
            S_CFG_ARM:     if (tick) nxt = S_CFG_ENTER;
            S_CFG_ENTER:   if (tick) nxt = S_CFG_LOW;
            S_CFG_LOW:     if (tick) nxt = S_CFG_HIGH;
            S_CFG_HIGH:    if (tick) nxt = last_cfg ? S_CFG_COMMIT : S_CFG_LOW;
            S_CFG_COMMIT:  if (tick) nxt = S_CFG_RELEASE;
            S_CFG_RELEASE: if (tick) nxt = S_IDLE;
            S_CNV_WAIT: begin
                if (sdi)          nxt = S_CNV_DROP;
                else if (tmo_hit) nxt = S_IDLE;
            end
            S_CNV_DROP:    if (tick) nxt = S_RD_HIGH;
            S_RD_HIGH:     if (tick) nxt = last_rd ? S_IDLE : S_RD_LOW;
            S_RD_LOW:      if (tick) nxt = S_RD_HIGH;
            default:       nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // counters and configuration shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tmo_cnt <= '0;
            cfg_sh  <= '0;
        end else begin
            if (state == S_IDLE)
                bit_cnt <= '0;
            else if (((state == S_CFG_HIGH) || (state == S_RD_HIGH)) && tick)
                bit_cnt <= bit_cnt + 1'b1;

            if (state == S_CNV_WAIT) tmo_cnt <= tmo_cnt + 1'b1;
            else                     tmo_cnt <= '0;

            if (cfg_ok)
                cfg_sh <= {N_DEV{cfg_word}};
            else if ((state == S_CFG_HIGH) && tick)
                cfg_sh <= {cfg_sh[CFG_BITS-2:0], 1'b0};
        end
    end

    // registered line levels, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk        <= 1'b0;
            cnvst       <= 1'b0;
            rd_valid    <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            sclk  <= (nxt == S_CFG_ARM) || (nxt == S_CFG_ENTER) || (nxt == S_CFG_HIGH) ||
                     (nxt == S_CFG_COMMIT) || (nxt == S_RD_HIGH);
            cnvst <= (nxt == S_CFG_ARM) || (nxt == S_CFG_COMMIT) ||
                     (nxt == S_CFG_RELEASE) || (nxt == S_CNV_WAIT);
            rd_valid <= rx_commit;
            if (cnv_ok)
                timeout_err <= 1'b0;
            else if ((state == S_CNV_WAIT) && !sdi && tmo_hit)
                timeout_err <= 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!sclk && !cnvst)); // R1
    AST_CFG_ENTRY_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CFG_ENTER) && $fell(cnvst)) |-> (sclk && $past(sclk))); // R2
    AST_COMMIT_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CFG_COMMIT) && $rose(cnvst)) |-> (sclk && (bit_cnt == CNT_W'(CFG_BITS)))); // R4
    AST_WAIT_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CNV_WAIT) |-> (!sclk && cnvst)); // R5
    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!cnvst && (state == S_IDLE))); // R6
    AST_READ_CNVST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RD_HIGH) || (state == S_RD_LOW)) |-> !cnvst); // R7
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bit_cnt == CNT_W'(FRAME_W))); // R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R10
    AST_WAIT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CNV_WAIT) && ($past(state) != S_CNV_WAIT))
            |-> (($past(state) == S_IDLE) && !$past(start_config))); // R12

endmodule

// File: tb/adc_chain_ctrl_tb_top.sv
module adc_chain_ctrl_tb_top;

    localparam int T = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_config = 1'b0, start_convert = 1'b0;
    logic [7:0]  cfg_word = 8'hC0;
    logic [3:0]  sclk_half = 4'd1;
    logic        sdi_drv = 1'b0;
    logic        sclk, cnvst, sdo, busy, rd_valid, timeout_err;
    logic [47:0] rd_data;

    adc_chain_ctrl #(.TIMEOUT_CYC(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_config(start_config), .start_convert(start_convert),
        .cfg_word(cfg_word), .sclk_half(sclk_half), .sdi(sdi_drv), .sclk(sclk), .cnvst(cnvst),
        .sdo(sdo), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .timeout_err(timeout_err)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // observation and chain model, all at the falling system clock edge
    logic        p_sclk = 0, p_cnvst = 0;
    logic        load_mode = 0, after_commit = 0, commit_sclk = 0;
    logic [23:0] cap = 0, commit_val = 0;
    int          cap_n = 0, commit_n = 0, commit_cnt = 0, pc_fall = 0;
    int          hi_run = 0, entry_hi_run = 0;
    logic [48:0] frame = 0;
    logic        rd_armed = 0, rise_bad = 0;
    int          idx = 0, nrise = 0, first_rise = 0, last_rise = 0;
    int          cnvst_rise = 0, cnvst_fall = 0, vcnt = 0, v_cyc = 0;

    always @(negedge clk) begin
        if (p_cnvst && !cnvst && p_sclk && sclk) begin
            load_mode = 1; cap = 0; cap_n = 0; entry_hi_run = hi_run;
        end
        if (load_mode && sclk && !p_sclk) begin
            cap = {cap[22:0], sdo}; cap_n++;
        end
        if (after_commit && !sclk && p_sclk && cnvst) pc_fall++;
        if (after_commit && !cnvst) after_commit = 0;
        if (load_mode && cnvst && !p_cnvst) begin
            load_mode = 0; commit_val = cap; commit_n = cap_n; commit_cnt++;
            commit_sclk = sclk; after_commit = 1;
        end
        if (cnvst && !p_cnvst) cnvst_rise = cyc;
        if (!cnvst && p_cnvst) cnvst_fall = cyc;
        if (rd_armed) begin
            if (sclk && !p_sclk) begin
                nrise++;
                if (nrise == 1) first_rise = cyc;
                last_rise = cyc;
                if (cnvst) rise_bad = 1;
            end
            if (!sclk && p_sclk) begin
                idx++;
                sdi_drv = (idx < 49) ? frame[48-idx] : 1'b0;
                if (idx >= 49) rd_armed = 0;
            end
        end
        if (rd_valid) begin vcnt++; v_cyc = cyc; end
        if (sclk) hi_run++; else hi_run = 0;
        p_sclk = sclk; p_cnvst = cnvst;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 20000);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_cnvst();
        int n = 0;
        while (!cnvst && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic run_config(input logic [3:0] h, input logic [7:0] w);
        int cc0, pc0;
        cc0 = commit_cnt; pc0 = pc_fall;
        sclk_half = h;
        @(negedge clk) cfg_word = w; start_config = 1;
        @(negedge clk) start_config = 0;
        chk("R12", "busy during load", busy, 1);
        wait_idle();
        chk("R2", "sclk high before load entry", 64'(entry_hi_run >= ((h == 0) ? 1 : h)), 1);
        chk("R3", "bits shifted", commit_n, 24);
        chk("R3", "configuration stream", commit_val, {3{w}});
        chk("R4", "commit count", commit_cnt, cc0 + 1);
        chk("R4", "sclk high at commit", commit_sclk, 1);
        chk("R4", "single trailing fall", pc_fall, pc0 + 1);
        chk("R1", "idle lines after load", {sclk, cnvst, sdo, busy}, 0);
    endtask

    task automatic run_conv(input logic [3:0] h, input int j, input logic [15:0] w0, w1, w2);
        int he, v0;
        he = (h == 0) ? 1 : h;
        sclk_half = h; frame = {1'b1, w0, w1, w2}; idx = 0; nrise = 0; rise_bad = 0; v0 = vcnt;
        @(negedge clk) start_convert = 1;
        @(negedge clk) start_convert = 0;
        wait_cnvst();
        chk("R6", "error cleared on start", timeout_err, 0);
        chk("R5", "sclk low while waiting", sclk, 0);
        if (j > 1) repeat (j - 1) @(negedge clk);
        sdi_drv = 1; rd_armed = 1;
        wait_idle();
        chk("R5", "wait length", cnvst_fall - cnvst_rise, j);
        chk("R6", "no error when ready in time", timeout_err, 0);
        chk("R7", "cnvst low at readout edges", rise_bad, 0);
        chk("R11", "first edge after cnvst fall", first_rise - cnvst_fall, he);
        chk("R8", "readout edge count", nrise, 49);
        chk("R8", "gapless span", last_rise - first_rise, 96 * he);
        chk("R9", "result words", rd_data, {w2, w1, w0});
        chk("R10", "valid pulses", vcnt, v0 + 1);
        chk("R10", "valid timing", v_cyc - last_rise, he);
    endtask

    task automatic run_timeout(input logic [3:0] h);
        int v0;
        logic [47:0] d0;
        v0 = vcnt; d0 = rd_data; sclk_half = h; nrise = 0; idx = 0; frame = 0; rd_armed = 1;
        @(negedge clk) start_convert = 1;
        @(negedge clk) start_convert = 0;
        wait_cnvst();
        wait_idle();
        rd_armed = 0;
        chk("R6", "error flag", timeout_err, 1);
        chk("R6", "timeout length", cnvst_fall - cnvst_rise, T);
        chk("R6", "no clock after timeout", nrise, 0);
        chk("R6", "no valid after timeout", vcnt, v0);
        chk("R10", "data held", rd_data, d0);
        repeat (10) @(negedge clk);
        chk("R6", "error flag sticky", timeout_err, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset lines", {sclk, cnvst, sdo, busy, rd_valid, timeout_err}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", {sclk, cnvst, sdo, busy, rd_valid, timeout_err}, 0);

        for (int h = 0; h < 4; h++) begin
            run_config(4'(h), 8'hC0);
            run_config(4'(h), 8'(8'hA5 + h * 8'h13));
        end

        for (int h = 0; h < 4; h++) begin
            for (int s = 0; s < 3; s++) begin
                int j;
                j = (s == 0) ? 1 : (s == 1) ? 3 + h : T;
                run_conv(4'(h), j, 16'((h * 7919 + j * 131) ^ 16'hA55A),
                         16'((h * 4001 + j * 977) ^ 16'h0F0F), 16'((h * 257 + j) ^ 16'h8001));
            end
        end
        run_conv(4'd2, 2, 16'hFFFF, 16'h0000, 16'h8001);

        run_timeout(4'd1);
        run_conv(4'd1, T, 16'h1357, 16'h2468, 16'hACE0);
        run_timeout(4'd3);
        run_conv(4'd3, 1, 16'h0001, 16'h8000, 16'h7FFE);

        // both requests in one idle cycle: only a load follows
        begin
            int cc0, v0;
            cc0 = commit_cnt; v0 = vcnt;
            @(negedge clk) cfg_word = 8'h5A; start_config = 1; start_convert = 1;
            @(negedge clk) start_config = 0; start_convert = 0;
            wait_idle();
            repeat (5) @(negedge clk);
            chk("R12", "load wins tie", commit_cnt, cc0 + 1);
            chk("R12", "tie stream", commit_val, {3{8'h5A}});
            chk("R12", "no conversion after tie", {busy, cnvst}, 0);
            chk("R12", "no valid after tie", vcnt, v0);
        end

        // convert request during a load is dropped
        begin
            int cc0;
            cc0 = commit_cnt;
            @(negedge clk) cfg_word = 8'h3C; start_config = 1;
            @(negedge clk) start_config = 0;
            repeat (4) @(negedge clk);
            start_convert = 1;
            @(negedge clk) start_convert = 0;
            wait_idle();
            repeat (5) @(negedge clk);
            chk("R12", "load completed", commit_cnt, cc0 + 1);
            chk("R12", "convert ignored while busy", {busy, cnvst}, 0);
        end

        // load request during a conversion wait is dropped
        begin
            int cc0, v0;
            cc0 = commit_cnt; v0 = vcnt; sclk_half = 4'd2;
            frame = {1'b1, 16'hBEEF, 16'h0F1E, 16'h2D3C}; idx = 0; nrise = 0;
            @(negedge clk) start_convert = 1;
            @(negedge clk) start_convert = 0;
            repeat (3) @(negedge clk);
            start_config = 1;
            @(negedge clk) start_config = 0;
            sdi_drv = 1; rd_armed = 1;
            wait_idle();
            chk("R12", "load ignored while busy", commit_cnt, cc0);
            chk("R12", "conversion still completes", vcnt, v0 + 1);
            chk("R9", "words after ignored load", rd_data, {16'h2D3C, 16'h0F1E, 16'hBEEF});
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule